// File: doc/BRIEF.md
# Slew-Limited Closed-Loop Bias Controller

This block produces a 12-bit converter code that steers a measured 12-bit sample toward a requested target code. A change of target is never applied in one jump. A ramp generator takes the distance from the present set-point to the new target and splits it into a fixed number of equal sub-steps. It applies one sub-step on each control tick, and the final sub-step lands exactly on the target. The 4-bit settling setting picks how many sub-steps the ramp uses, which sets the total ramp time at one sub-step per 200 µs control period.

On every tick, a saturating digital integrator adds the difference between the ramped set-point and the measured sample to its accumulator. The accumulator is the output code. When the loop has settled, the sample equals the set-point and the code holds still. Software, or a neighbouring block, provides the tick, the target, the setting and the loop enable. The block reports whether a ramp is in progress and whether the present setting is one it does not support.

Top module: `bias_ramp_loop`

## Requirements
- R1: While reset is asserted and on the first cycle after it, setpoint, dac, busy and bad_setting are all zero.
- R2: setpoint changes only on the clock after a cycle with tick high. While loop_en is high, dac changes only on the clock after a tick.
- R3: The setting code k selects the number of sub-steps N for a ramp: k=0..10 give N = 4, 8, 12, 16, 24, 32, 48, 64, 96, 128, 144. A ramp reaches the target on the N-th tick after the target change was taken.
- R4: Every sub-step except the last adds the signed distance (target minus set-point at capture) divided by N, rounded toward zero.
- R5: The last sub-step sets setpoint exactly equal to the target.
- R6: A target change during a ramp starts a new ramp from the present setpoint. The new ramp uses the setting present at that clock.
- R7: bad_setting is high on the clock after setting holds a code from 11 to 15, and low on the clock after setting holds a code from 0 to 10.
- R8: On a tick while setting is invalid, setpoint is set directly to the target and busy goes low. A target taken under an invalid setting is reached on the next tick.
- R9: On each tick with loop_en high, dac becomes dac + setpoint - adc. The setpoint used is the value before that tick.
- R10: dac saturates at 0 and at 4095 and never wraps.
- R11: On the clock after loop_en is low, dac is zero.
- R12: busy goes high on the tick that applies a non-final sub-step. It goes low on the tick that lands on the target, or when a new target equals the present setpoint.
- R13: If target changes on the same clock as a tick, that clock takes the new target and applies no sub-step. setpoint stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Single-cycle control period strobe |
| target | input | 12 | Requested set-point code |
| setting | input | 4 | Settling-time selection |
| adc | input | 12 | Measured sample code |
| loop_en | input | 1 | Integrator enable; low clears the accumulator |
| setpoint | output | 12 | Ramped set-point |
| dac | output | 12 | Integrator output code |
| busy | output | 1 | Ramp in progress |
| bad_setting | output | 1 | Setting code is unsupported |

## Verification
The bench drives a downward ramp whose distance does not divide by the step count. A design that rounded the increment the wrong way, or skipped the final correction, would stop short of the target or overshoot it. It changes the target in the middle of a long ramp and again on the very clock of a tick. A design that restarted from the old start point, or stepped and captured in the same cycle, would put the set-point on a wrong value. It drives the accumulator into both rails. A wrapping adder would jump from near 4095 to a small code, or from near zero to a large one. It also selects an unsupported setting, where a design that kept ramping, or that never applied the target, would leave the set-point off target.

// File: rtl/bias_loop_pkg.sv
package bias_loop_pkg;

  // Width of the sub-step counter; must hold the largest step count.
  localparam int STEP_W = 8;

  // Decoded settling selection.
  typedef struct packed {
    logic              valid;
    logic [STEP_W-1:0] steps;
  } step_cfg_t;

endpackage

// File: rtl/bias_step_lut.sv
module bias_step_lut #(
  parameter int SET_W = 4
) (
  input  logic [SET_W-1:0]        code,
  output bias_loop_pkg::step_cfg_t cfg
);
  import bias_loop_pkg::*;

  // Each sub-step lasts one control period, so steps = ramp time / period.
  always_comb begin
    cfg.valid = 1'b1;
    case (code)
      SET_W'(0):  cfg.steps = STEP_W'(4);
      SET_W'(1):  cfg.steps = STEP_W'(8);
      SET_W'(2):  cfg.steps = STEP_W'(12);
      SET_W'(3):  cfg.steps = STEP_W'(16);
      SET_W'(4):  cfg.steps = STEP_W'(24);
      SET_W'(5):  cfg.steps = STEP_W'(32);
      SET_W'(6):  cfg.steps = STEP_W'(48);
      SET_W'(7):  cfg.steps = STEP_W'(64);
      SET_W'(8):  cfg.steps = STEP_W'(96);
      SET_W'(9):  cfg.steps = STEP_W'(128);
      SET_W'(10): cfg.steps = STEP_W'(144);
      default: begin
        cfg.valid = 1'b0;
        cfg.steps = '0;
      end
    endcase
  end

endmodule

// File: rtl/bias_ramp_gen.sv
module bias_ramp_gen #(
  parameter int CODE_W = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick,
  input  logic [CODE_W-1:0]        target,
  input  bias_loop_pkg::step_cfg_t cfg,
  output logic [CODE_W-1:0]        setpoint,
  output logic                     busy,
  output logic                     capture,
  output logic [CODE_W-1:0]        tgt_q
);
  import bias_loop_pkg::*;

  localparam int DW = CODE_W + 1;  // signed distance width

  logic [CODE_W-1:0] sp_q, sp_n, tgt_n;
  logic [STEP_W-1:0] cnt_q, cnt_n;
  logic signed [DW-1:0] inc_q, inc_n;
  logic busy_q, busy_n;

  logic signed [DW-1:0] delta, divisor, inc_calc, sum_s;
  logic                 upd_en;

  assign capture  = (target != tgt_q);
  assign delta    = $signed({1'b0, target}) - $signed({1'b0, sp_q});
  assign divisor  = cfg.valid ? $signed({{(DW-STEP_W){1'b0}}, cfg.steps})
                              : $signed(DW'(1));
  assign inc_calc = delta / divisor;
  assign sum_s    = $signed({1'b0, sp_q}) + inc_q;
  assign upd_en   = capture | tick;

  always_comb begin
    sp_n   = sp_q;
    tgt_n  = tgt_q;
    cnt_n  = cnt_q;
    inc_n  = inc_q;
    busy_n = busy_q;
    if (capture) begin
      // New target wins over a coincident tick: no step this cycle.
      tgt_n = target;
      if (delta == '0) begin
        cnt_n  = '0;
        busy_n = 1'b0;
      end else if (!cfg.valid) begin
        cnt_n = STEP_W'(1);
        inc_n = '0;
      end else begin
        cnt_n = cfg.steps;
        inc_n = inc_calc;
      end
    end else if (tick) begin
      if (!cfg.valid) begin
        sp_n   = tgt_q;
        cnt_n  = '0;
        busy_n = 1'b0;
      end else if (cnt_q != '0) begin
        if (cnt_q == STEP_W'(1)) begin
          sp_n   = tgt_q;
          busy_n = 1'b0;
        end else begin
          sp_n   = sum_s[CODE_W-1:0];
          busy_n = 1'b1;
        end
        cnt_n = cnt_q - STEP_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q   <= '0;
      tgt_q  <= '0;
      cnt_q  <= '0;
      inc_q  <= '0;
      busy_q <= 1'b0;
    end else if (upd_en) begin
      sp_q   <= sp_n;
      tgt_q  <= tgt_n;
      cnt_q  <= cnt_n;
      inc_q  <= inc_n;
      busy_q <= busy_n;
    end
  end

  assign setpoint = sp_q;
  assign busy     = busy_q;

endmodule

// File: rtl/bias_err_integrator.sv
module bias_err_integrator #(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              loop_en,
  input  logic [CODE_W-1:0] setpoint,
  input  logic [CODE_W-1:0] adc,
  output logic [CODE_W-1:0] acc
);
  localparam int SUM_W = CODE_W + 2;
  localparam logic signed [SUM_W-1:0] TOP_S = SUM_W'((1 << CODE_W) - 1);

  logic [CODE_W-1:0] acc_q, acc_n;
  logic signed [SUM_W-1:0] sum_s;
  logic upd_en;

  assign sum_s  = $signed({2'b00, acc_q}) + $signed({2'b00, setpoint})
                - $signed({2'b00, adc});
  assign upd_en = tick | ~loop_en;

  always_comb begin
    if (!loop_en)         acc_n = '0;
    else if (sum_s < 0)   acc_n = '0;
    else if (sum_s > TOP_S) acc_n = '1;
    else                  acc_n = sum_s[CODE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (upd_en) acc_q <= acc_n;
  end

  assign acc = acc_q;

endmodule

// File: rtl/bias_ramp_loop.sv
module bias_ramp_loop #(
  parameter int CODE_W = 12,
  parameter int SET_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [CODE_W-1:0] target,
  input  logic [SET_W-1:0]  setting,
  input  logic [CODE_W-1:0] adc,
  input  logic              loop_en,
  output logic [CODE_W-1:0] setpoint,
  output logic [CODE_W-1:0] dac,
  output logic              busy,
  output logic              bad_setting
);
  import bias_loop_pkg::*;

  step_cfg_t         cfg;
  logic              capture;
  logic [CODE_W-1:0] tgt_q;
  logic              bad_q, bad_n;

  bias_step_lut #(.SET_W(SET_W)) u_lut (
    .code (setting),
    .cfg  (cfg)
  );

  bias_ramp_gen #(.CODE_W(CODE_W)) u_ramp (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .target   (target),
    .cfg      (cfg),
    .setpoint (setpoint),
    .busy     (busy),
    .capture  (capture),
    .tgt_q    (tgt_q)
  );

  bias_err_integrator #(.CODE_W(CODE_W)) u_int (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .loop_en  (loop_en),
    .setpoint (setpoint),
    .adc      (adc),
    .acc      (dac)
  );

  assign bad_n = ~cfg.valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bad_q <= 1'b0;
    else        bad_q <= bad_n;
  end

  assign bad_setting = bad_q;

endmodule

// File: rtl/bias_ramp_loop_chk.sv
module bias_ramp_loop_chk #(
  parameter int CODE_W = 12,
  parameter int SET_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic [SET_W-1:0]  setting,
  input logic              loop_en,
  input logic [CODE_W-1:0] setpoint,
  input logic [CODE_W-1:0] dac,
  input logic              busy,
  input logic              bad_setting,
  input logic              capture,
  input logic [CODE_W-1:0] tgt_q
);
  localparam int LAST_OK = 10;

  p_sp_tick_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(setpoint));

  p_dac_tick_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_en && !tick) |=> $stable(dac));

  p_loop_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_en |=> (dac == '0));

  p_bad_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (setting > SET_W'(LAST_OK)) |=> bad_setting);

  p_bad_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (setting <= SET_W'(LAST_OK)) |=> !bad_setting);

  p_direct_jump_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !capture && setting > SET_W'(LAST_OK))
      |=> (setpoint == $past(tgt_q) && !busy));

  p_busy_end_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (setpoint == tgt_q));

  p_capture_no_step_r13: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> $stable(setpoint));

endmodule

bind bias_ramp_loop bias_ramp_loop_chk #(.CODE_W(CODE_W), .SET_W(SET_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick        (tick),
  .setting     (setting),
  .loop_en     (loop_en),
  .setpoint    (setpoint),
  .dac         (dac),
  .busy        (busy),
  .bad_setting (bad_setting),
  .capture     (capture),
  .tgt_q       (tgt_q)
);

// File: tb/bias_ramp_loop_bench.sv
module bias_ramp_loop_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int WATCHDOG   = 50000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick;
  logic [11:0] target = '0;
  logic [3:0]  setting = '0;
  logic [11:0] adc = '0;
  logic        loop_en = 1'b0;
  logic [11:0] setpoint, dac;
  logic        busy, bad_setting;

  int checks = 0;
  int errors = 0;
  int div_cnt = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) div_cnt <= (div_cnt == TICK_DIV-1) ? 0 : div_cnt + 1;
  assign tick = (div_cnt == TICK_DIV-1);

  bias_ramp_loop u_bias_ramp_loop (
    .clk(clk), .rst_n(rst_n), .tick(tick), .target(target), .setting(setting),
    .adc(adc), .loop_en(loop_en), .setpoint(setpoint), .dac(dac),
    .busy(busy), .bad_setting(bad_setting)
  );

  // ---------------- behavioural reference ----------------
  int m_sp = 0, m_tgt = 0, m_cnt = 0, m_inc = 0, m_busy = 0, m_bad = 0, m_acc = 0;

  function automatic int steps_for(int code);
    case (code)
      0: return 4;    1: return 8;    2: return 12;  3: return 16;
      4: return 24;   5: return 32;   6: return 48;  7: return 64;
      8: return 96;   9: return 128;  10: return 144;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sp = 0; m_tgt = 0; m_cnt = 0; m_inc = 0; m_busy = 0; m_bad = 0; m_acc = 0;
    end else begin
      int n, d, s;
      n = steps_for(int'(setting));
      m_bad = (n == 0);
      if (!loop_en) m_acc = 0;
      else if (tick) begin
        s = m_acc + m_sp - int'(adc);
        m_acc = (s < 0) ? 0 : (s > 4095) ? 4095 : s;
      end
      if (int'(target) != m_tgt) begin
        m_tgt = int'(target);
        d = m_tgt - m_sp;
        if (d == 0) begin m_cnt = 0; m_busy = 0; end
        else if (n == 0) begin m_cnt = 1; m_inc = 0; end
        else begin m_cnt = n; m_inc = d / n; end
      end else if (tick) begin
        if (n == 0) begin m_sp = m_tgt; m_cnt = 0; m_busy = 0; end
        else if (m_cnt != 0) begin
          if (m_cnt == 1) begin m_sp = m_tgt; m_busy = 0; end
          else begin m_sp = m_sp + m_inc; m_busy = 1; end
          m_cnt = m_cnt - 1;
        end
      end
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3 R4 R5 R6 R8 R13 setpoint model", int'(setpoint), m_sp);
      chk("R9 R10 R11 dac model", int'(dac), m_acc);
      chk("R12 busy model", int'(busy), m_busy);
      chk("R7 bad_setting model", int'(bad_setting), m_bad);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wait_tick(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk iff tick);
      @(negedge clk);
    end
  endtask

  // ---------------- directed scenario ----------------
  initial begin
    repeat (3) @(negedge clk);
    chk("R1 setpoint in reset", int'(setpoint), 0);
    chk("R1 dac in reset", int'(dac), 0);
    chk("R1 busy in reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 bad_setting after reset", int'(bad_setting), 0);

    // Upward ramp, 4 sub-steps of 100.
    target = 12'd400;
    wait_tick(1);
    chk("R4 first step", int'(setpoint), 100);
    chk("R12 busy during ramp", int'(busy), 1);
    wait_tick(2);
    chk("R12 busy before last step", int'(busy), 1);
    wait_tick(1);
    chk("R3 four ticks reach target", int'(setpoint), 400);
    chk("R12 busy low at arrival", int'(busy), 0);

    // Downward, not divisible: -297/8 -> -37.
    setting = 4'd1;
    target  = 12'd103;
    wait_tick(1);
    chk("R4 truncated step toward zero", int'(setpoint), 363);
    wait_tick(6);
    chk("R4 seventh step", int'(setpoint), 141);
    wait_tick(1);
    chk("R5 exact landing", int'(setpoint), 103);

    // Long ramp interrupted mid-way.
    setting = 4'd10;
    target  = 12'd4000;
    wait_tick(5);
    chk("R4 long ramp step 27", int'(setpoint), 238);
    @(negedge clk);
    chk("R2 setpoint holds between ticks", int'(setpoint), 238);
    setting = 4'd2;
    target  = 12'd1000;
    wait_tick(1);
    chk("R6 restart from present value", int'(setpoint), 301);
    wait_tick(10);
    chk("R6 eleventh step", int'(setpoint), 931);
    wait_tick(1);
    chk("R5 landing after restart", int'(setpoint), 1000);

    // Target change on a tick clock.
    setting = 4'd0;
    @(negedge clk iff tick);
    target = 12'd500;
    @(negedge clk);
    chk("R13 no step on capture tick", int'(setpoint), 1000);
    wait_tick(1);
    chk("R13 first step after capture", int'(setpoint), 875);
    wait_tick(3);
    chk("R5 landing at 500", int'(setpoint), 500);

    // Invalid setting.
    setting = 4'd12;
    @(negedge clk);
    chk("R7 flag for code 12", int'(bad_setting), 1);
    target = 12'd2000;
    wait_tick(1);
    chk("R8 direct jump", int'(setpoint), 2000);
    chk("R8 busy low", int'(busy), 0);
    setting = 4'd3;
    @(negedge clk);
    chk("R7 flag clears", int'(bad_setting), 0);

    // Integrator.
    adc = 12'd0;
    loop_en = 1'b1;
    wait_tick(1);
    chk("R9 accumulate error", int'(dac), 2000);
    wait_tick(1);
    chk("R9 second accumulation", int'(dac), 4000);
    wait_tick(1);
    chk("R10 top saturation", int'(dac), 4095);
    adc = 12'd4095;
    wait_tick(1);
    chk("R9 negative error", int'(dac), 2000);
    wait_tick(1);
    chk("R10 bottom saturation", int'(dac), 0);
    adc = 12'd2000;
    wait_tick(2);
    chk("R9 steady state holds", int'(dac), 0);
    adc = 12'd1500;
    wait_tick(1);
    chk("R9 small error", int'(dac), 500);
    loop_en = 1'b0;
    @(negedge clk);
    chk("R11 disable clears", int'(dac), 0);

    repeat (4) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule